// File: doc/BRIEF.md
# L2 Hit/Miss Predictor

This per-core block guesses, for every new L1 load miss, whether the request will also miss in the shared L2 cache. Network interface logic uses the guess to set a priority bit before the request is sent. The guess comes back combinationally in the same cycle as the request. When the response later arrives carrying its true L2-miss flag, the core feeds that outcome back through the update port to train the predictor.

Two schemes sit side by side, and `mode_sel` picks one at run time. In pattern mode, a shift register holds the last M true outcomes. That register indexes a table of 2-bit saturating counters, and the selected counter gives the guess. Every guess returns the history value it used. The requester carries that value with the request and hands it back with the outcome, so training hits the same counter even after the history has moved on. In burst mode, a window of M requests is counted together with the number of confirmed L2 misses seen during that window. When a window closes, its verdict is latched and used for every guess in the following window.

Top module: `l2_miss_guess`

## Requirements
- R1: After reset, every pattern counter holds 01 (weak hit), the history register is zero, the burst verdict is hit (0) and both window counters are zero. So `pred_miss` is 0 and `pred_hist` is 0.
- R2: With `mode_sel`=0, `pred_miss` equals bit 1 of the counter indexed by the current history, so counter values 2 and 3 predict a miss.
- R3: Each `upd_valid` cycle shifts `upd_l2miss` into bit 0 of the history and drops bit M-1. `pred_hist` always shows the history.
- R4: An update trains the counter at index `upd_hist`, not the one at the current history. A miss increments it and stops at 3. A hit decrements it and stops at 0.
- R5: Each `pred_req` cycle advances a window count. On the M-th request the verdict becomes (confirmed misses in the window, including an update in that same cycle) > `thresh`, and both counts restart at zero.
- R6: With `mode_sel`=1, `pred_miss` equals the latched verdict, which stays unchanged for every cycle of the window in progress.
- R7: The confirmed-miss count of a window saturates at M.
- R8: In any cycle where `mode_sel` differs from its value in the previous cycle (0 after reset), all state of both schemes returns to the R1 values, and that cycle's request and update are dropped.
- R9: M defaults to 8. `thresh` is CW = clog2(M+1) bits wide and is sampled when a window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = pattern-history scheme, 1 = burst-window scheme |
| thresh | input | CW | Miss count that a window must exceed to predict a miss |
| pred_req | input | 1 | A new L1 load miss asks for a guess this cycle |
| pred_miss | output | 1 | Guess: 1 = L2 miss expected |
| pred_hist | output | M | History value behind the guess, to be carried with the request |
| upd_valid | input | 1 | A response with a known L2 status has returned |
| upd_hist | input | M | History value carried by that request |
| upd_l2miss | input | 1 | Response flag: 1 = the access missed in L2 |

## Verification
The embedded properties watch, on every cycle, that the window and miss counts stay in range, that a window restarts after its M-th request, that the verdict only changes when a window closes or the mode flips, and that a mode flip wipes history, counts and verdict. The values themselves can only be shown by the bench's scenarios, which compare the outputs against a reference model. Those values are: which counter an update trains when the history has moved on, counter saturation at both ends, whether the closing update is counted, saturation of the miss count against a high threshold, and the dropping of a request and an update in the cycle of a mode flip.

// File: rtl/l2_miss_guess.sv
module l2_miss_guess #(
  parameter int M  = 8,
  parameter int CW = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic [CW-1:0] thresh,
  input  logic          pred_req,
  output logic          pred_miss,
  output logic [M-1:0]  pred_hist,
  input  logic          upd_valid,
  input  logic [M-1:0]  upd_hist,
  input  logic          upd_l2miss
);
  localparam int ENT = 1 << M;
  localparam int WW  = (M > 1) ? $clog2(M) : 1;
  localparam logic [WW-1:0] WLAST = WW'(M - 1);
  localparam logic [CW-1:0] CMAX  = CW'(M);

  logic [1:0]    tbl [ENT];
  logic [M-1:0]  hist;
  logic          mode_q;
  logic [WW-1:0] win;
  logic [CW-1:0] mcnt;
  logic          verdict;

  wire chg     = mode_sel != mode_q;
  wire win_end = pred_req && (win == WLAST);
  wire [CW-1:0] mcnt_nx = (upd_valid && upd_l2miss && mcnt != CMAX) ? mcnt + 1'b1 : mcnt;

  assign pred_hist = hist;
  assign pred_miss = mode_sel ? verdict : tbl[hist][1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) tbl[i] <= 2'b01;
    end else if (chg) begin
      for (int i = 0; i < ENT; i++) tbl[i] <= 2'b01;
    end else if (upd_valid) begin
      if (upd_l2miss && tbl[upd_hist] != 2'b11)
        tbl[upd_hist] <= tbl[upd_hist] + 2'b01;
      else if (!upd_l2miss && tbl[upd_hist] != 2'b00)
        tbl[upd_hist] <= tbl[upd_hist] - 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      hist    <= '0;
      win     <= '0;
      mcnt    <= '0;
      verdict <= 1'b0;
    end else begin
      mode_q <= mode_sel;
      if (chg) begin
        hist    <= '0;
        win     <= '0;
        mcnt    <= '0;
        verdict <= 1'b0;
      end else begin
        if (upd_valid) hist <= {hist[M-2:0], upd_l2miss};
        if (win_end) begin
          win     <= '0;
          mcnt    <= '0;
          verdict <= mcnt_nx > thresh;
        end else begin
          if (pred_req) win <= win + 1'b1;
          mcnt <= mcnt_nx;
        end
      end
    end
  end

  assert_miss_cnt_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt <= CMAX);

  assert_win_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win <= WLAST);

  assert_win_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !chg) |=> (win == '0 && mcnt == '0));

  assert_win_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_req && !win_end && !chg) |=> (win == $past(win) + 1'b1));

  assert_verdict_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && !chg) |=> $stable(verdict));

  assert_mode_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (hist == '0 && win == '0 && mcnt == '0 && !verdict));
endmodule

// File: tb/l2_miss_guess_test.sv
`timescale 1ns/1ps
module l2_miss_guess_test;
  localparam int M  = 8;
  localparam int CW = $clog2(M + 1);

  logic clk = 1'b0, rst_n = 1'b0, mode_sel = 1'b0;
  logic [CW-1:0] thresh = '0;
  logic pred_req = 1'b0, upd_valid = 1'b0, upd_l2miss = 1'b0;
  logic [M-1:0] upd_hist = '0;
  logic pred_miss;
  logic [M-1:0] pred_hist;

  int n_cmp = 0, n_bad = 0;

  int m_tbl [1 << M];
  int m_hist, m_win, m_cnt, m_ver, m_mode;

  always #2.5 clk = ~clk;

  l2_miss_guess #(.M(M), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .thresh(thresh),
    .pred_req(pred_req), .pred_miss(pred_miss), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_hist(upd_hist), .upd_l2miss(upd_l2miss));

  function automatic void model_clear();
    for (int i = 0; i < (1 << M); i++) m_tbl[i] = 1;
    m_hist = 0; m_win = 0; m_cnt = 0; m_ver = 0;
  endfunction

  function automatic int exp_miss(input bit md);
    return md ? m_ver : (m_tbl[m_hist] >= 2 ? 1 : 0);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit md, input bit req, input bit uv, input int uh,
                      input bit um, input int th, input string tag);
    int nx;
    @(negedge clk);
    mode_sel = md; pred_req = req; upd_valid = uv; upd_hist = M'(uh);
    upd_l2miss = um; thresh = CW'(th);
    #1;
    if (md == m_mode) begin
      chk(tag, pred_miss, exp_miss(md));
      chk("R3", pred_hist, m_hist);
    end
    @(posedge clk);
    if (md != m_mode) begin
      model_clear();
    end else begin
      if (uv) begin
        if (um && m_tbl[uh] < 3) m_tbl[uh]++;
        if (!um && m_tbl[uh] > 0) m_tbl[uh]--;
        m_hist = ((m_hist << 1) | um) & ((1 << M) - 1);
      end
      nx = m_cnt + ((uv && um && m_cnt < M) ? 1 : 0);
      if (req && m_win == M - 1) begin
        m_ver = (nx > th) ? 1 : 0; m_win = 0; m_cnt = 0;
      end else begin
        m_win += req; m_cnt = nx;
      end
    end
    m_mode = md;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear(); m_mode = 0;
    #12 rst_n = 1'b1;
    // R1: reset state
    @(negedge clk); #1;
    chk("R1", pred_miss, 0);
    chk("R1", pred_hist, 0);
    // R4: train counter 0 to saturation, walk history elsewhere, then back
    step(0, 0, 1, 0, 1, 0, "R2");
    step(0, 0, 1, 0, 1, 0, "R2");
    step(0, 0, 1, 0, 1, 0, "R4");
    for (int i = 0; i < M; i++) step(0, 1, 1, 5, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R4");
    chk("R4", pred_miss, 1);
    // R8: flip to burst mode with request and update in the flip cycle
    step(1, 1, 1, 0, 1, 2, "R8");
    step(1, 0, 0, 0, 0, 2, "R8");
    chk("R8", pred_hist, 0);
    chk("R8", pred_miss, 0);
    // R5: window with 3 misses above thresh 2, last one in the closing cycle
    for (int i = 0; i < M; i++) step(1, 1, (i == 1 || i == 4 || i == M - 1), 0, 1, 2, "R6");
    step(1, 0, 0, 0, 0, 2, "R5");
    chk("R5", pred_miss, 1);
    // R6: window with 2 misses at thresh 2; old verdict held until close
    for (int i = 0; i < M; i++) step(1, 1, (i < 2), 0, 1, 2, "R6");
    step(1, 0, 0, 0, 0, 2, "R6");
    chk("R6", pred_miss, 0);
    // R7: 11 misses saturate at M, thresh M gives hit; R9 thresh full width
    for (int i = 0; i < 11; i++) step(1, 0, 1, 0, 1, M, "R6");
    for (int i = 0; i < M; i++) step(1, 1, 0, 0, 0, M, "R7");
    step(1, 0, 0, 0, 0, M, "R7");
    chk("R7", pred_miss, 0);
    for (int i = 0; i < M; i++) step(1, 1, (i < 3), 0, 1, 0, "R9");
    step(1, 0, 0, 0, 0, 0, "R9");
    chk("R9", pred_miss, 1);
    // R8: flip back to pattern mode wipes counters
    step(0, 1, 1, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");
    chk("R8", pred_miss, 0);
    // random mix
    for (int n = 0; n < 6000; n++) begin
      bit md;
      md = (($urandom % 64) == 0) ? ~m_mode[0] : m_mode[0];
      step(md, $urandom % 2, $urandom % 2, $urandom % (1 << M),
           ($urandom % 3) != 0, $urandom % (M + 1), md ? "R6" : "R2");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule